// File: doc/BRIEF.md
# Peripheral Clock and Reset Gating Controller

This block holds the software-visible state that turns peripheral clocks on and off and holds peripherals in reset. Clock enables sit in banks of 32. Each bank has three registers: a set register, a clear register and a status register. Software can switch one clock without a read-modify-write cycle. Writing 1s to the set register turns the matching clocks on. Writing 1s to the clear register turns them off. The status register reports the result.

Reset lines are active-low read/write words. The lines are numbered from the least significant bit of the first word upward. Clearing a bit holds its peripheral in reset, and setting the bit lets the peripheral run.

Every output comes straight from a flop in the register clock domain. Downstream gate cells and per-domain reset synchronisers consume these outputs. The block has one write strobe. Reads return data combinationally for the address on the bus.

Top module: `pgc_ctrl`

## Requirements
- R1: A write of a word to a bank's set register (bank 0 at offset 0x014, bank 1 at 0x020) turns on every clock enable whose bit in that word is 1. The change appears at the outputs after the clock edge that takes the write. Clock line 32*b+i is bit i of bank b.
- R2: A write of a word to a bank's clear register (bank 0 at 0x018, bank 1 at 0x024) turns off every clock enable whose bit in that word is 1. The change appears after the clock edge that takes the write.
- R3: Bits written as 0 to a set or clear register leave the matching clock enables unchanged.
- R4: Reading a bank's status register (bank 0 at 0x01C, bank 1 at 0x028) returns that bank's current clock enables. Reading its set or clear register returns the same value.
- R5: Writes to a status register change no clock enable and no reset line.
- R6: While rst_n is low at a clock edge, the clock enables load the parameter CLK_EN_DEFAULT and every reset line goes to 0, which holds every peripheral in reset.
- R7: The reset words at 0x02C, 0x030 and 0x034 are read/write. Bit i of word w drives reset line 32*w+i, and a 0 on a line holds its peripheral in reset. Line 63 is therefore bit 31 of the word at 0x030. A write replaces the whole word, and a read returns it.
- R8: Reads from any other offset return 0. Writes to any other offset change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wen | input | 1 | Write strobe, taken at the rising edge |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| clk_en_o | output | 64 | Per-peripheral clock enables, active high |
| periph_rst_n_o | output | 96 | Per-peripheral resets, active low |

## Verification
The assertions assume that bus_addr is word-aligned whenever bus_wen is high. They also assume that reset is held for at least one clock edge before the first access. The bench drives only aligned offsets, and it changes bus inputs on the falling edge so each write is seen at exactly one rising edge. The read-data checks assume bus_addr is stable during the high phase of the clock. The bench keeps it stable across every sampled read.

// File: rtl/pgc_pkg.sv
// Shared constants for the peripheral clock/reset gating controller.
// Assumes byte addressing with 32-bit registers on a word-aligned map.
package pgc_pkg;
    localparam int unsigned REG_BYTES   = 4;
    localparam int unsigned BANK_REGS   = 3;
    localparam int unsigned BANK_STRIDE = REG_BYTES * BANK_REGS;

    // Role of a register inside one clock bank, in address order.
    typedef enum logic [1:0] {
        CK_SET  = 2'd0,
        CK_CLR  = 2'd1,
        CK_STAT = 2'd2
    } ck_role_e;
endpackage

// File: rtl/pgc_addr_dec.sv
// Address decoder: turns a byte offset into one-hot hit vectors for the
// set/clear/status registers of each clock bank and for each reset word.
// Assumes the bank and reset regions do not overlap (checked by the caller's
// choice of base parameters).
module pgc_addr_dec
    import pgc_pkg::*;
#(
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned NUM_CLK_BANKS = 2,
    parameter int unsigned NUM_RST_WORDS = 3,
    parameter int unsigned CLK_BASE      = 'h14,
    parameter int unsigned RST_BASE      = 'h2C
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic [NUM_CLK_BANKS-1:0] set_hit,
    output logic [NUM_CLK_BANKS-1:0] clr_hit,
    output logic [NUM_CLK_BANKS-1:0] stat_hit,
    output logic [NUM_RST_WORDS-1:0] rst_hit
);
    // One comparator triple per clock bank.
    for (genvar b = 0; b < NUM_CLK_BANKS; b++) begin : g_bank
        localparam int unsigned BASE_B = CLK_BASE + b * BANK_STRIDE;
        assign set_hit[b]  = (addr == ADDR_W'(BASE_B + int'(CK_SET)  * REG_BYTES));
        assign clr_hit[b]  = (addr == ADDR_W'(BASE_B + int'(CK_CLR)  * REG_BYTES));
        assign stat_hit[b] = (addr == ADDR_W'(BASE_B + int'(CK_STAT) * REG_BYTES));
    end

    // One comparator per reset word.
    for (genvar w = 0; w < NUM_RST_WORDS; w++) begin : g_rst
        assign rst_hit[w] = (addr == ADDR_W'(RST_BASE + w * REG_BYTES));
    end
endmodule

// File: rtl/pgc_clk_bank.sv
// One bank of clock enables with write-one-to-set and write-one-to-clear
// access. Assumes set_we and clr_we are never high together (one bus port).
module pgc_clk_bank #(
    parameter int unsigned DATA_W    = 32,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] state
);
    // Enable state: load default in reset, OR in set bits, mask off clear bits.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= RESET_VAL;
        else if (set_we) state <= state | wdata;
        else if (clr_we) state <= state & ~wdata;
    end

    // R1
    set_bits_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((state & $past(wdata)) == $past(wdata)));
    // R2
    clr_bits_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((state & $past(wdata)) == '0));
    // R3
    zero_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we || clr_we) |=> ((state & ~$past(wdata)) == ($past(state) & ~$past(wdata))));
    // R5
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(state));
endmodule

// File: rtl/pgc_rst_word.sv
// One word of active-low peripheral reset lines, plain read/write.
// Assumes a zero power-on value, so every peripheral starts held in reset.
module pgc_rst_word #(
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    // Reset word storage: clear in reset, replace on write.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    // R7
    rst_word_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (q == $past(wdata)));
    // R7
    rst_word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/pgc_ctrl.sv
// Peripheral clock and reset gating controller (top).
// Decodes a simple write-strobe bus onto clock-enable banks and reset words,
// and returns read data combinationally. Assumes word-aligned accesses.
module pgc_ctrl
    import pgc_pkg::*;
#(
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned DATA_W        = 32,
    parameter int unsigned NUM_CLK_BANKS = 2,
    parameter int unsigned NUM_RST_WORDS = 3,
    parameter int unsigned CLK_BASE      = 'h14,
    parameter int unsigned RST_BASE      = 'h2C,
    parameter logic [NUM_CLK_BANKS*DATA_W-1:0] CLK_EN_DEFAULT = 64'h0000_0400_0001_0000
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bus_wen,
    input  logic [ADDR_W-1:0]               bus_addr,
    input  logic [DATA_W-1:0]               bus_wdata,
    output logic [DATA_W-1:0]               bus_rdata,
    output logic [NUM_CLK_BANKS*DATA_W-1:0] clk_en_o,
    output logic [NUM_RST_WORDS*DATA_W-1:0] periph_rst_n_o
);
    localparam int unsigned NUM_CLKS = NUM_CLK_BANKS * DATA_W;
    localparam int unsigned NUM_RSTS = NUM_RST_WORDS * DATA_W;

    logic [NUM_CLK_BANKS-1:0] set_hit, clr_hit, stat_hit;
    logic [NUM_RST_WORDS-1:0] rst_hit;
    logic [DATA_W-1:0]        bank_state [NUM_CLK_BANKS];
    logic [DATA_W-1:0]        rst_q      [NUM_RST_WORDS];
    logic                     any_hit;

    pgc_addr_dec #(
        .ADDR_W(ADDR_W), .NUM_CLK_BANKS(NUM_CLK_BANKS), .NUM_RST_WORDS(NUM_RST_WORDS),
        .CLK_BASE(CLK_BASE), .RST_BASE(RST_BASE)
    ) u_dec (
        .addr(bus_addr), .set_hit(set_hit), .clr_hit(clr_hit),
        .stat_hit(stat_hit), .rst_hit(rst_hit)
    );

    // Clock banks; the status register has no write path.
    for (genvar b = 0; b < NUM_CLK_BANKS; b++) begin : g_clk
        pgc_clk_bank #(
            .DATA_W(DATA_W),
            .RESET_VAL(CLK_EN_DEFAULT[b*DATA_W +: DATA_W])
        ) u_bank (
            .clk(clk), .rst_n(rst_n),
            .set_we(bus_wen && set_hit[b]),
            .clr_we(bus_wen && clr_hit[b]),
            .wdata(bus_wdata),
            .state(bank_state[b])
        );
        assign clk_en_o[b*DATA_W +: DATA_W] = bank_state[b];
    end

    // Reset words, LSB-first line numbering across words.
    for (genvar w = 0; w < NUM_RST_WORDS; w++) begin : g_rst
        pgc_rst_word #(.DATA_W(DATA_W)) u_word (
            .clk(clk), .rst_n(rst_n),
            .we(bus_wen && rst_hit[w]),
            .wdata(bus_wdata),
            .q(rst_q[w])
        );
        assign periph_rst_n_o[w*DATA_W +: DATA_W] = rst_q[w];
    end

    // Read mux: any register of a bank returns its status; unmapped reads 0.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_CLK_BANKS; b++)
            if (set_hit[b] || clr_hit[b] || stat_hit[b]) bus_rdata = bank_state[b];
        for (int w = 0; w < NUM_RST_WORDS; w++)
            if (rst_hit[w]) bus_rdata = rst_q[w];
    end

    assign any_hit = (|set_hit) || (|clr_hit) || (|stat_hit) || (|rst_hit);

    // R4
    rdata_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_hit[0] || clr_hit[0] || stat_hit[0]) |-> (bus_rdata == clk_en_o[DATA_W-1:0]));
    // R7
    rdata_rst0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_hit[0] |-> (bus_rdata == periph_rst_n_o[DATA_W-1:0]));
    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |-> (bus_rdata == '0));
    // R8
    unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && !any_hit) |=> ($stable(clk_en_o) && $stable(periph_rst_n_o)));
    // R5
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && (|stat_hit)) |=> ($stable(clk_en_o) && $stable(periph_rst_n_o)));

    // Width sanity for the concatenated outputs.
    initial begin
        assert (NUM_CLKS == $bits(clk_en_o) && NUM_RSTS == $bits(periph_rst_n_o));
    end
endmodule

// File: tb/tb_pgc_ctrl.sv
`timescale 1ns/1ps
module tb_pgc_ctrl;
    localparam logic [63:0] DEF = 64'h0000_0400_0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] clk_en_o;
    logic [95:0] periph_rst_n_o;

    int checks = 0;
    int errors = 0;
    logic [63:0] exp_clk;
    logic [95:0] exp_rst;

    always #10 clk = ~clk;

    pgc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .clk_en_o(clk_en_o), .periph_rst_n_o(periph_rst_n_o)
    );

    task automatic check(input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(req, {64'h0, bus_rdata}, {64'h0, exp});
    endtask

    task automatic outs_check(input string req);
        check(req, {32'h0, clk_en_o}, {32'h0, exp_clk});
        check(req, periph_rst_n_o, exp_rst);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        exp_clk = DEF;
        exp_rst = '0;
    endtask

    task automatic t_reset_state();
        do_reset();
        outs_check("R6 reset defaults");
        rd_check("R6 status0 after reset", 8'h1C, DEF[31:0]);
    endtask

    task automatic t_set();
        wr(8'h14, 32'h0000_00F0);
        exp_clk[31:0] = exp_clk[31:0] | 32'h0000_00F0;
        outs_check("R1 set bank0");
        wr(8'h20, 32'h8000_0000);
        exp_clk[63:32] = exp_clk[63:32] | 32'h8000_0000;
        outs_check("R1 set bank1 line 63");
    endtask

    task automatic t_clear();
        wr(8'h18, 32'h0001_0010);
        exp_clk[31:0] = exp_clk[31:0] & ~32'h0001_0010;
        outs_check("R2 clear bank0 (R3 others kept)");
        wr(8'h24, 32'h0000_0400);
        exp_clk[63:32] = exp_clk[63:32] & ~32'h0000_0400;
        outs_check("R2 clear bank1");
    endtask

    task automatic t_zero_write();
        wr(8'h14, 32'h0);
        outs_check("R3 zero set write");
        wr(8'h24, 32'h0);
        outs_check("R3 zero clear write");
    endtask

    task automatic t_readback();
        rd_check("R4 bank0 via set", 8'h14, exp_clk[31:0]);
        rd_check("R4 bank0 via clear", 8'h18, exp_clk[31:0]);
        rd_check("R4 bank0 status", 8'h1C, exp_clk[31:0]);
        rd_check("R4 bank1 via set", 8'h20, exp_clk[63:32]);
        rd_check("R4 bank1 via clear", 8'h24, exp_clk[63:32]);
        rd_check("R4 bank1 status", 8'h28, exp_clk[63:32]);
    endtask

    task automatic t_status_write();
        wr(8'h1C, 32'hFFFF_FFFF);
        outs_check("R5 status0 write ignored");
        wr(8'h28, 32'h0000_0000);
        outs_check("R5 status1 write ignored");
    endtask

    task automatic t_resets();
        wr(8'h2C, 32'hA5A5_0001);
        exp_rst[31:0] = 32'hA5A5_0001;
        outs_check("R7 reset word0");
        wr(8'h30, 32'h8000_0000);
        exp_rst[63:32] = 32'h8000_0000;
        outs_check("R7 line 63 released");
        check("R7 line 63 bit", {95'h0, periph_rst_n_o[63]}, 96'h1);
        wr(8'h34, 32'h0000_0030);
        exp_rst[95:64] = 32'h0000_0030;
        outs_check("R7 reset word2");
        wr(8'h2C, 32'h0000_0000);
        exp_rst[31:0] = 32'h0;
        outs_check("R7 reset word0 reasserted");
        rd_check("R7 readback word1", 8'h30, 32'h8000_0000);
        rd_check("R7 readback word2", 8'h34, 32'h0000_0030);
    endtask

    task automatic t_unmapped();
        wr(8'h40, 32'hFFFF_FFFF);
        outs_check("R8 unmapped write");
        wr(8'h10, 32'hFFFF_FFFF);
        outs_check("R8 unmapped write below map");
        rd_check("R8 unmapped read 0x40", 8'h40, 32'h0);
        rd_check("R8 unmapped read 0x38", 8'h38, 32'h0);
    endtask

    initial begin
        #(20.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_clk = DEF;
        exp_rst = '0;
        t_reset_state();
        t_set();
        t_clear();
        t_zero_write();
        t_readback();
        t_status_write();
        t_resets();
        t_unmapped();
        do_reset();
        outs_check("R6 reset after activity");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule